// File: doc/BRIEF.md
# Clock Lane High-Speed Entry and Exit Sequencer

This block steps the clock lane of a serial camera or display physical-layer transmitter through the line states that take it from low-power signalling into continuous high-speed clocking and back out again. It does no analog work. It drives a two-bit low-power line state, an enable for the high-speed driver, an enable for clock toggling, and a flag telling the data lanes that the clock has run long enough for them to begin their own entry. Every interval is a programmable count of reference-clock cycles that firmware computes elsewhere from the bit rate. The sequencer captures all of those counts at the moment it leaves the stop state, so they cannot change mid-sequence.

The sequence runs through nine states. IDLE_LP11 drives the stop state. A request moves it to HS_RQST, which drives LP-01. It then passes through PREPARE (LP-00) and ZERO (high-speed driver on, clock held at zero), and then PRE, where the clock toggles but the data lanes are still held back. ACTIVE raises the ready flag. ACTIVE is left only when the request is withdrawn and all data lanes report low power. The lane then passes through POST (the clock keeps toggling), TRAIL (high-speed zero) and EXIT (LP-11), and returns to IDLE_LP11. Each timed state advances when its down-counter expires. IDLE_LP11 and ACTIVE advance on their inputs.

Top module: `clk_lane_seq`

## Requirements
- R1: Out of reset and while in IDLE_LP11, lp_state is 2'b11 and hs_en, clk_toggle_en and data_ready are all low. lp_state bit 1 is the P line and bit 0 is the N line. data_lp_done has no effect in this state.
- R2: A high hs_req sampled in IDLE_LP11 moves the lane to HS_RQST on that edge. HS_RQST drives lp_state 2'b01, with the other outputs low, for max(lpx_cyc,1) cycles.
- R3: PREPARE follows HS_RQST. It drives lp_state 2'b00 with hs_en low for max(prep_cyc,1) cycles.
- R4: ZERO follows PREPARE. It drives lp_state 2'b00 with hs_en high and clk_toggle_en low for max(zero_cyc,1) cycles.
- R5: PRE follows ZERO. hs_en and clk_toggle_en are high and data_ready is low for max(pre_cyc,1) cycles, so the clock toggles before any data lane may start.
- R6: ACTIVE follows PRE. It raises data_ready with hs_en and clk_toggle_en high. It lasts at least one cycle and stays until an edge in ACTIVE samples hs_req low and data_lp_done high.
- R7: POST follows ACTIVE. The clock keeps toggling with data_ready low for max(post_cyc,1) cycles.
- R8: TRAIL follows POST. It keeps hs_en high with clk_toggle_en low for max(trail_cyc,1) cycles.
- R9: EXIT follows TRAIL. It drives lp_state 2'b11 with all enables low for max(exit_cyc,1) cycles and then returns to IDLE_LP11. A request that arrives during the exit neither shortens it nor skips the single IDLE_LP11 cycle that precedes re-entry.
- R10: All seven durations are captured on the edge that leaves IDLE_LP11. Changes to the duration inputs after that edge do not affect the running sequence.
- R11: Dropping hs_req or raising data_lp_done before ACTIVE is reached does not abort or shorten the entry steps.
- R12: lp_state never shows 2'b10. data_ready is never high without both hs_en and clk_toggle_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_req | input | 1 | Level request for high-speed clocking |
| data_lp_done | input | 1 | All data lanes are back in low power |
| lpx_cyc | input | CNT_W | HS_RQST duration in cycles |
| prep_cyc | input | CNT_W | PREPARE duration in cycles |
| zero_cyc | input | CNT_W | ZERO duration in cycles |
| pre_cyc | input | CNT_W | PRE duration in cycles |
| post_cyc | input | CNT_W | POST duration in cycles |
| trail_cyc | input | CNT_W | TRAIL duration in cycles |
| exit_cyc | input | CNT_W | EXIT duration in cycles |
| lp_state | output | 2 | Low-power line state, bit 1 = P, bit 0 = N |
| hs_en | output | 1 | High-speed driver enable |
| clk_toggle_en | output | 1 | High-speed clock toggle enable |
| data_ready | output | 1 | Data lanes may begin high-speed entry |

## Verification
Two events can fall on the same edge. The first is the expiry of the PRE counter while the data lanes are already signalling low power with the request withdrawn. The bench provokes this by releasing the request before ACTIVE is reached. It expects exactly one ACTIVE cycle with data_ready high, followed directly by POST. The second is the expiry of the EXIT counter while a new request is pending. The bench raises hs_req in the first POST cycle and expects the full EXIT count, one IDLE_LP11 cycle and then HS_RQST. Every cycle is compared against a timeline that the bench computes from the programmed durations.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

    typedef enum logic [3:0] {
        IDLE_LP11 = 4'd0,
        HS_RQST   = 4'd1,
        PREPARE   = 4'd2,
        ZERO      = 4'd3,
        PRE       = 4'd4,
        ACTIVE    = 4'd5,
        POST      = 4'd6,
        TRAIL     = 4'd7,
        EXIT      = 4'd8
    } lane_state_e;

    localparam int NUM_DUR   = 7;
    localparam int DUR_LPX   = 0;
    localparam int DUR_PREP  = 1;
    localparam int DUR_ZERO  = 2;
    localparam int DUR_PRE   = 3;
    localparam int DUR_POST  = 4;
    localparam int DUR_TRAIL = 5;
    localparam int DUR_EXIT  = 6;

    localparam logic [1:0] LP_STOP   = 2'b11;
    localparam logic [1:0] LP_REQ    = 2'b01;
    localparam logic [1:0] LP_BRIDGE = 2'b00;

    // Duration slot used by a timed state; untimed states return slot 0.
    function automatic int dur_slot(lane_state_e s);
        unique case (s)
            HS_RQST: return DUR_LPX;
            PREPARE: return DUR_PREP;
            ZERO:    return DUR_ZERO;
            PRE:     return DUR_PRE;
            POST:    return DUR_POST;
            TRAIL:   return DUR_TRAIL;
            EXIT:    return DUR_EXIT;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/clk_lane_dur_reg.sv
module clk_lane_dur_reg #(
    parameter int CNT_W = 8,
    parameter int NUM   = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture,
    input  logic [NUM-1:0][CNT_W-1:0] live,
    output logic [NUM-1:0][CNT_W-1:0] eff
);

    logic [NUM-1:0][CNT_W-1:0] held;

    for (genvar g = 0; g < NUM; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held[g] <= '0;
            end else if (capture) begin
                held[g] <= live[g];
            end
        end

        // While capturing, the live value is used so the first timed state
        // loads the same count that is being stored.
        assign eff[g] = capture ? live[g] : held[g];
    end

endmodule

// File: rtl/clk_lane_timer.sv
module clk_lane_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            // A programmed zero behaves as one cycle.
            cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/clk_lane_fsm.sv
module clk_lane_fsm
    import clk_lane_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hs_req,
    input  logic                          data_lp_done,
    input  logic                          expired,
    input  logic [NUM_DUR-1:0][CNT_W-1:0] eff,
    output logic                          capture,
    output logic                          load,
    output logic [CNT_W-1:0]              load_val,
    output logic [1:0]                    lp_state,
    output logic                          hs_en,
    output logic                          clk_toggle_en,
    output logic                          data_ready
);

    lane_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IDLE_LP11;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            IDLE_LP11: if (hs_req)                 nxt = HS_RQST;
            HS_RQST:   if (expired)                nxt = PREPARE;
            PREPARE:   if (expired)                nxt = ZERO;
            ZERO:      if (expired)                nxt = PRE;
            PRE:       if (expired)                nxt = ACTIVE;
            ACTIVE:    if (!hs_req && data_lp_done) nxt = POST;
            POST:      if (expired)                nxt = TRAIL;
            TRAIL:     if (expired)                nxt = EXIT;
            EXIT:      if (expired)                nxt = IDLE_LP11;
            default:                               nxt = IDLE_LP11;
        endcase
    end

    assign capture  = (state == IDLE_LP11);
    assign load     = (nxt != state);
    assign load_val = eff[dur_slot(nxt)];

    always_comb begin
        lp_state      = LP_BRIDGE;
        hs_en         = 1'b0;
        clk_toggle_en = 1'b0;
        data_ready    = 1'b0;
        unique case (state)
            IDLE_LP11: lp_state = LP_STOP;
            HS_RQST:   lp_state = LP_REQ;
            PREPARE:   lp_state = LP_BRIDGE;
            ZERO:      hs_en = 1'b1;
            PRE: begin
                hs_en         = 1'b1;
                clk_toggle_en = 1'b1;
            end
            ACTIVE: begin
                hs_en         = 1'b1;
                clk_toggle_en = 1'b1;
                data_ready    = 1'b1;
            end
            POST: begin
                hs_en         = 1'b1;
                clk_toggle_en = 1'b1;
            end
            TRAIL:     hs_en = 1'b1;
            EXIT:      lp_state = LP_STOP;
            default:   lp_state = LP_STOP;
        endcase
    end

endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq
    import clk_lane_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_req,
    input  logic             data_lp_done,
    input  logic [CNT_W-1:0] lpx_cyc,
    input  logic [CNT_W-1:0] prep_cyc,
    input  logic [CNT_W-1:0] zero_cyc,
    input  logic [CNT_W-1:0] pre_cyc,
    input  logic [CNT_W-1:0] post_cyc,
    input  logic [CNT_W-1:0] trail_cyc,
    input  logic [CNT_W-1:0] exit_cyc,
    output logic [1:0]       lp_state,
    output logic             hs_en,
    output logic             clk_toggle_en,
    output logic             data_ready
);

    logic [NUM_DUR-1:0][CNT_W-1:0] live_dur;
    logic [NUM_DUR-1:0][CNT_W-1:0] eff_dur;
    logic                          capture;
    logic                          load;
    logic [CNT_W-1:0]              load_val;
    logic                          expired;

    always_comb begin
        live_dur[DUR_LPX]   = lpx_cyc;
        live_dur[DUR_PREP]  = prep_cyc;
        live_dur[DUR_ZERO]  = zero_cyc;
        live_dur[DUR_PRE]   = pre_cyc;
        live_dur[DUR_POST]  = post_cyc;
        live_dur[DUR_TRAIL] = trail_cyc;
        live_dur[DUR_EXIT]  = exit_cyc;
    end

    clk_lane_dur_reg #(.CNT_W(CNT_W), .NUM(NUM_DUR)) dur_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .live    (live_dur),
        .eff     (eff_dur)
    );

    clk_lane_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    clk_lane_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .hs_req        (hs_req),
        .data_lp_done  (data_lp_done),
        .expired       (expired),
        .eff           (eff_dur),
        .capture       (capture),
        .load          (load),
        .load_val      (load_val),
        .lp_state      (lp_state),
        .hs_en         (hs_en),
        .clk_toggle_en (clk_toggle_en),
        .data_ready    (data_ready)
    );

endmodule

// File: rtl/clk_lane_seq_chk.sv
module clk_lane_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_req,
    input logic       data_lp_done,
    input logic [1:0] lp_state,
    input logic       hs_en,
    input logic       clk_toggle_en,
    input logic       data_ready
);

    // R12
    lp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_state != 2'b10);

    // R12
    ready_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> (hs_en && clk_toggle_en));

    // R2
    req_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_state == 2'b01 && $past(lp_state) != 2'b01) |-> $past(lp_state) == 2'b11);

    // R4
    hs_after_bridge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> ($past(lp_state) == 2'b00 && !clk_toggle_en));

    // R5
    toggle_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_toggle_en) |-> ($past(hs_en) && !data_ready));

    // R5
    ready_after_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(clk_toggle_en));

    // R6
    ready_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_ready) |-> ($past(data_lp_done) && !$past(hs_req) && clk_toggle_en));

    // R9
    exit_to_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_en) |-> (lp_state == 2'b11 && $past(!clk_toggle_en)));

endmodule

bind clk_lane_seq clk_lane_seq_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .hs_req        (hs_req),
    .data_lp_done  (data_lp_done),
    .lp_state      (lp_state),
    .hs_en         (hs_en),
    .clk_toggle_en (clk_toggle_en),
    .data_ready    (data_ready)
);

// File: tb/clk_lane_seq_tb_top.sv
module clk_lane_seq_tb_top;

    localparam int CLK_P = 10;
    localparam int CW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hs_req = 1'b0;
    logic          data_lp_done = 1'b0;
    logic [CW-1:0] lpx_cyc = '0, prep_cyc = '0, zero_cyc = '0, pre_cyc = '0;
    logic [CW-1:0] post_cyc = '0, trail_cyc = '0, exit_cyc = '0;
    logic [1:0]    lp_state;
    logic          hs_en, clk_toggle_en, data_ready;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    clk_lane_seq #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .data_lp_done(data_lp_done),
        .lpx_cyc(lpx_cyc), .prep_cyc(prep_cyc), .zero_cyc(zero_cyc), .pre_cyc(pre_cyc),
        .post_cyc(post_cyc), .trail_cyc(trail_cyc), .exit_cyc(exit_cyc),
        .lp_state(lp_state), .hs_en(hs_en), .clk_toggle_en(clk_toggle_en),
        .data_ready(data_ready)
    );

    function automatic int at_least1(int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic check(input logic [4:0] exp, input string tag, input int k);
        logic [4:0] act;
        act = {lp_state, hs_en, clk_toggle_en, data_ready};
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s offset %0d: act lp/hs/tog/rdy=%b expected %b", tag, k, act, exp);
        end
    endtask

    // One full sequence, starting at a falling edge with the lane in IDLE_LP11.
    task automatic run_seq(input int l, input int p, input int z, input int pr,
                           input int po, input int tr, input int ex,
                           input int rel_mode, input bit rereq);
        int b1, b2, b3, b4, a_end, p_end, t_end, e_end, k_rel;
        b1 = at_least1(l);
        b2 = b1 + at_least1(p);
        b3 = b2 + at_least1(z);
        b4 = b3 + at_least1(pr);
        k_rel = (rel_mode == 0) ? 1 : (rel_mode == 1) ? b4 + 1 : b4 + 3;
        a_end = (k_rel > b4 + 1) ? k_rel : b4 + 1;
        p_end = a_end + at_least1(po);
        t_end = p_end + at_least1(tr);
        e_end = t_end + at_least1(ex);
        lpx_cyc = CW'(l); prep_cyc = CW'(p); zero_cyc = CW'(z); pre_cyc = CW'(pr);
        post_cyc = CW'(po); trail_cyc = CW'(tr); exit_cyc = CW'(ex);
        hs_req = 1'b1;
        data_lp_done = 1'b0;
        for (int k = 1; k <= e_end + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k <= b1)         check(5'b01000, "R2", k);
            else if (k <= b2)    check(5'b00000, "R3", k);
            else if (k <= b3)    check(5'b00100, "R4", k);
            else if (k <= b4)    check(5'b00110, "R5", k);
            else if (k <= a_end) check(5'b00111, "R6", k);
            else if (k <= p_end) check(5'b00110, "R7", k);
            else if (k <= t_end) check(5'b00100, "R8", k);
            else if (k <= e_end) check(5'b11000, "R9", k);
            else                 check(5'b11000, "R9_idle", k);
            if (k == 1) begin
                // R10: later changes to the duration inputs are ignored
                lpx_cyc = 8'hF1; prep_cyc = 8'hE2; zero_cyc = 8'hD3; pre_cyc = 8'hC4;
                post_cyc = 8'hB5; trail_cyc = 8'hA6; exit_cyc = 8'h97;
            end
            if (k == k_rel) begin
                // R11 when released before ACTIVE; R6 otherwise
                hs_req = 1'b0;
                data_lp_done = 1'b1;
            end
            if (rereq && k == a_end + 1) begin
                hs_req = 1'b1;
                data_lp_done = 1'b0;
            end
        end
        if (!rereq) begin
            hs_req = 1'b0;
            data_lp_done = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        check(5'b11000, "R1", 0);
        rst_n = 1'b1;
        // R1: idle stays put, data_lp_done has no effect
        for (int i = 0; i < 4; i++) begin
            data_lp_done = i[0];
            @(negedge clk);
            check(5'b11000, "R1", i);
        end
        data_lp_done = 1'b0;
        idx = 0;
        for (int l = 0; l < 3; l++)
            for (int p = 0; p < 3; p++)
                for (int z = 0; z < 3; z++)
                    for (int pr = 0; pr < 3; pr++) begin
                        run_seq(l, p, z, pr, (l + p) % 4, (z + pr) % 3, (l + z + 1) % 4,
                                idx % 3, idx[0]);
                        idx++;
                    end
        run_seq(9, 5, 7, 12, 30, 6, 11, 2, 1'b1);
        run_seq(3, 4, 2, 8, 20, 3, 5, 0, 1'b0);
        repeat (2) @(negedge clk);
        check(5'b11000, "R1", 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule